// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a physical address. It walks a four-level hierarchy of translation tables that sits in memory. A requester presents the virtual address, the kind of access (read, write or instruction fetch), a flag that marks a user-mode access, and the frame number of the top-level table. The walker then reads one 64-bit table entry per level over a simple memory port, and it never has more than one read in flight. At each level it checks the entry and either descends to the next table, ends the walk early on a large page, or stops with a fault.

The result is held at the output until the requester acknowledges it. A good result carries the physical address, the page size and the level where the walk ended. A fault result carries a fault code and the level that caused it. The walker takes no new request while a walk is running or while a result is waiting to be acknowledged.

Top module: `pt_walker`

## Requirements
- R1: The four 9-bit table indices are taken from virtual address bits 47:39 (level 4, read first), 38:30 (level 3), 29:21 (level 2) and 20:12 (level 1). Each read address is the table base plus index times 8, so its low 3 bits are always zero. The level-4 table base is `root_frame` shifted left by 12.
- R2: In every entry, bits 47:12 are a frame number. Shifted left by 12, this frame number becomes the base of the next table. For a 4 KB page, the physical address is that frame number joined with virtual address bits 11:0.
- R3: An entry with bit 0 clear ends the walk with fault code 1 (not present), and `res_level` gives the level of that entry.
- R4: If bit 7 is set in a level-3 entry, the walk ends with `res_page_size`=2 (1 GB) and physical address {entry[47:30], va[29:0]}. If bit 7 is set in a level-2 entry, it ends with `res_page_size`=1 (2 MB) and address {entry[47:21], va[20:0]}. In a level-1 entry, bit 7 has no effect and the result is `res_page_size`=0 (4 KB). On success the fault code is 0 and `res_level` gives the level that ended the walk.
- R5: Bit 7 set in a level-4 entry whose bit 0 is set gives fault code 2 (reserved bit), with level 4.
- R6: A write access (`req_kind`=1) that meets an entry with bit 1 clear at any level it visits gives fault code 3 (protection) at that level.
- R7: A user access (`req_user`=1) that meets an entry with bit 2 clear at any level it visits gives fault code 3 at that level. A supervisor access ignores bit 2.
- R8: A fetch (`req_kind`=2) that meets an entry with bit 63 set at any level it visits gives fault code 3 at that level. A read access (`req_kind`=0) ignores bit 63.
- R9: An entry whose frame number points back to its own table, or to an ancestor table, is followed like any other entry and is not treated as an error.
- R10: A virtual address whose bits 63:48 are not all copies of bit 47 gives fault code 4 (non-canonical) with level 0, and no memory read is issued.
- R11: A memory read request keeps `mem_req_valid` and `mem_req_addr` steady until `mem_req_ready` is seen. No new read is issued until the response of the last one has arrived.
- R12: `req_ready` is high only when no walk is running and no result is pending. A result stays valid and unchanged until `res_ack`. After reset, `req_ready` is 1 and `res_valid` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle; request accepted on this cycle if valid |
| req_vaddr | input | 64 | Virtual address to translate |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 for a user-mode access |
| root_frame | input | 36 | Frame number of the level-4 table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 48 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Entry contents |
| res_valid | output | 1 | Result present |
| res_ack | input | 1 | Requester takes the result |
| res_fault | output | 1 | Result is a fault |
| res_fault_code | output | 3 | 0 none, 1 not present, 2 reserved, 3 protection, 4 non-canonical |
| res_level | output | 3 | Level that ended the walk or faulted (0 for non-canonical) |
| res_paddr | output | 48 | Translated physical address |
| res_page_size | output | 2 | 0 4 KB, 1 2 MB, 2 1 GB |

## Verification
Directed walks go through one clean chain of four tables, changing a single entry each time. This shows whether the walker looks at the right bit at the right level: a page-size bit at levels 4, 3, 2 and 1 gives four different results, and a permission bit cleared at one level must fault only for the matching access kind or privilege. A chain that points back into its own root table checks that a repeated frame is followed, and that each read uses a fresh index. Several hundred random walks over a densely filled table pool mix present, permission, large-page and non-canonical cases. Together with random memory stall and latency, these catch errors in address forming, in offset merging and in the order in which the checks are applied.

// File: rtl/pt_walker.sv
`timescale 1ns/1ps
module pt_walker #(
  parameter int PA_W  = 48,
  parameter int IDX_W = 9,
  parameter int OFF_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [63:0]             req_vaddr,
  input  logic [1:0]              req_kind,
  input  logic                    req_user,
  input  logic [PA_W-OFF_W-1:0]   root_frame,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [PA_W-1:0]         mem_req_addr,
  input  logic                    mem_rsp_valid,
  input  logic [63:0]             mem_rsp_data,
  output logic                    res_valid,
  input  logic                    res_ack,
  output logic                    res_fault,
  output logic [2:0]              res_fault_code,
  output logic [2:0]              res_level,
  output logic [PA_W-1:0]         res_paddr,
  output logic [1:0]              res_page_size
);
  localparam int FRM_W = PA_W - OFF_W;
  localparam int VA_W  = OFF_W + 4 * IDX_W;
  localparam int G1_W  = OFF_W + 2 * IDX_W;
  localparam int M2_W  = OFF_W + IDX_W;

  localparam logic [2:0] F_NONE = 3'd0, F_NP = 3'd1, F_RSV = 3'd2, F_PROT = 3'd3, F_NC = 3'd4;
  localparam logic [1:0] K_WR = 2'd1, K_FETCH = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_L4, S_L3, S_L2, S_L1, S_DONE, S_FAULT} state_t;

  state_t            st;
  logic [VA_W-1:0]   va;
  logic [1:0]        kind;
  logic              usr;
  logic [FRM_W-1:0]  tbl;
  logic              waiting;
  logic [2:0]        fcode, flvl;
  logic [PA_W-1:0]   pa;
  logic [1:0]        psz;

  logic [2:0]        lvl;
  logic [IDX_W-1:0]  idx;
  logic [FRM_W-1:0]  efrm;
  logic              walking, canon, present, big, bad_perm, leaf;

  always_comb begin
    case (st)
      S_L4:    begin lvl = 3'd4; idx = va[OFF_W+3*IDX_W +: IDX_W]; end
      S_L3:    begin lvl = 3'd3; idx = va[OFF_W+2*IDX_W +: IDX_W]; end
      S_L2:    begin lvl = 3'd2; idx = va[OFF_W+IDX_W   +: IDX_W]; end
      default: begin lvl = 3'd1; idx = va[OFF_W         +: IDX_W]; end
    endcase
  end

  assign walking  = (st == S_L4) || (st == S_L3) || (st == S_L2) || (st == S_L1);
  assign canon    = req_vaddr[63:VA_W-1] == {(64-VA_W+1){req_vaddr[VA_W-1]}};
  assign efrm     = mem_rsp_data[PA_W-1:OFF_W];
  assign present  = mem_rsp_data[0];
  assign big      = mem_rsp_data[7];
  assign bad_perm = (kind == K_WR && !mem_rsp_data[1]) ||
                    (usr && !mem_rsp_data[2]) ||
                    (kind == K_FETCH && mem_rsp_data[63]);
  assign leaf     = (st == S_L1) || ((st == S_L3 || st == S_L2) && big);

  wire unused_bits = &{1'b0, mem_rsp_data[62:PA_W], mem_rsp_data[OFF_W-1:8], mem_rsp_data[6:3]};

  assign req_ready      = st == S_IDLE;
  assign mem_req_valid  = walking && !waiting;
  assign mem_req_addr   = {tbl, idx, 3'b000};
  assign res_valid      = (st == S_DONE) || (st == S_FAULT);
  assign res_fault      = st == S_FAULT;
  assign res_fault_code = fcode;
  assign res_level      = flvl;
  assign res_paddr      = pa;
  assign res_page_size  = psz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va      <= '0;
      kind    <= '0;
      usr     <= 1'b0;
      tbl     <= '0;
      waiting <= 1'b0;
      fcode   <= F_NONE;
      flvl    <= '0;
      pa      <= '0;
      psz     <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va    <= req_vaddr[VA_W-1:0];
          kind  <= req_kind;
          usr   <= req_user;
          tbl   <= root_frame;
          pa    <= '0;
          psz   <= '0;
          flvl  <= '0;
          fcode <= canon ? F_NONE : F_NC;
          st    <= canon ? S_L4 : S_FAULT;
        end
        S_L4, S_L3, S_L2, S_L1: begin
          if (!waiting) begin
            if (mem_req_ready) waiting <= 1'b1;
          end else if (mem_rsp_valid) begin
            waiting <= 1'b0;
            flvl    <= lvl;
            if (!present) begin
              fcode <= F_NP;
              st    <= S_FAULT;
            end else if (st == S_L4 && big) begin
              fcode <= F_RSV;
              st    <= S_FAULT;
            end else if (bad_perm) begin
              fcode <= F_PROT;
              st    <= S_FAULT;
            end else if (leaf) begin
              st <= S_DONE;
              if (st == S_L3) begin
                psz <= 2'd2;
                pa  <= {efrm[FRM_W-1:G1_W-OFF_W], va[G1_W-1:0]};
              end else if (st == S_L2) begin
                psz <= 2'd1;
                pa  <= {efrm[FRM_W-1:M2_W-OFF_W], va[M2_W-1:0]};
              end else begin
                psz <= 2'd0;
                pa  <= {efrm, va[OFF_W-1:0]};
              end
            end else begin
              tbl <= efrm;
              st  <= state_t'(st + 3'd1);
            end
          end
        end
        S_DONE, S_FAULT: if (res_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
`timescale 1ns/1ps
module pt_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [63:0] req_vaddr,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [47:0] mem_req_addr,
  input logic        mem_rsp_valid,
  input logic        res_valid,
  input logic        res_ack,
  input logic [2:0]  res_fault_code,
  input logic [2:0]  res_level,
  input logic [47:0] res_paddr
);
  logic outst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst <= 1'b0;
    else if (mem_req_valid && mem_req_ready) outst <= 1'b1;
    else if (mem_rsp_valid) outst <= 1'b0;
  end

  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !outst); // R11
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R11
  AST_ENTRY_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'b000); // R1
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ack |=> res_valid && $stable(res_paddr) && $stable(res_fault_code) && $stable(res_level)); // R12
  AST_IDLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !res_valid && !mem_req_valid); // R12
  AST_NONCANON: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_vaddr[63:48] != {16{req_vaddr[47]}})
    |=> res_valid && res_fault_code == 3'd4 && !mem_req_valid); // R10
endmodule

bind pt_walker pt_walker_chk i_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .res_valid(res_valid),
  .res_ack(res_ack), .res_fault_code(res_fault_code), .res_level(res_level),
  .res_paddr(res_paddr)
);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  localparam int NTBL = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        req_user = 1'b0;
  logic [35:0] root_frame = 36'd1;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [47:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        res_valid;
  logic        res_ack = 1'b0;
  logic        res_fault;
  logic [2:0]  res_fault_code;
  logic [2:0]  res_level;
  logic [47:0] res_paddr;
  logic [1:0]  res_page_size;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_kind(req_kind), .req_user(req_user), .root_frame(root_frame),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .res_valid(res_valid),
    .res_ack(res_ack), .res_fault(res_fault), .res_fault_code(res_fault_code),
    .res_level(res_level), .res_paddr(res_paddr), .res_page_size(res_page_size)
  );

  always #4 clk = ~clk;

  logic [63:0] pm [0:NTBL*512-1];
  int          checks = 0, fails = 0;
  int          nrd;
  logic [47:0] rd_addr [0:3];
  logic [47:0] cap_addr;
  int          rsp_wait = 0;

  logic [2:0]  exp_code, exp_lvl;
  logic [47:0] exp_pa;
  logic [1:0]  exp_ps;
  int          exp_nrd;
  logic [47:0] exp_addr [0:3];

  function automatic logic [63:0] rd(input logic [47:0] a);
    logic [35:0] f = a[47:12];
    if (f >= 1 && f <= NTBL) return pm[(int'(f) - 1) * 512 + int'(a[11:3])];
    return 64'd0;
  endfunction

  function automatic logic [63:0] mkent(input logic [35:0] frm, input logic [11:0] fl, input logic nx);
    return {nx, 15'd0, frm, fl};
  endfunction

  function automatic logic [63:0] mkva(input int i4, input int i3, input int i2, input int i1, input logic [11:0] off);
    logic [47:0] v = {i4[8:0], i3[8:0], i2[8:0], i1[8:0], off};
    return {{16{v[47]}}, v};
  endfunction

  task automatic put(input int frm, input int idx, input logic [63:0] v);
    pm[(frm - 1) * 512 + idx] = v;
  endtask

  task automatic model(input logic [63:0] va, input logic [1:0] kind, input logic usr, input logic [35:0] root);
    logic [47:0] base = {root, 12'd0};
    logic [63:0] e;
    exp_code = 3'd0; exp_lvl = 3'd0; exp_pa = '0; exp_ps = 2'd0; exp_nrd = 0;
    if (va[63:48] != {16{va[47]}}) begin
      exp_code = 3'd4;
      return;
    end
    for (int l = 4; l >= 1; l--) begin
      logic [8:0] ix = va[12 + 9 * (l - 1) +: 9];
      logic [47:0] a = base + {36'd0, ix, 3'b000};
      exp_addr[exp_nrd] = a;
      exp_nrd++;
      e = rd(a);
      exp_lvl = 3'(l);
      if (!e[0]) begin exp_code = 3'd1; return; end
      if (l == 4 && e[7]) begin exp_code = 3'd2; return; end
      if ((kind == 2'd1 && !e[1]) || (usr && !e[2]) || (kind == 2'd2 && e[63])) begin
        exp_code = 3'd3; return;
      end
      if (l == 3 && e[7]) begin exp_ps = 2'd2; exp_pa = {e[47:30], va[29:0]}; return; end
      if (l == 2 && e[7]) begin exp_ps = 2'd1; exp_pa = {e[47:21], va[20:0]}; return; end
      if (l == 1) begin exp_pa = {e[47:12], va[11:0]}; return; end
      base = {e[47:12], 12'd0};
    end
  endtask

  task automatic chk(input bit ok, input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (rsp_wait > 0) begin
        rsp_wait--;
        if (rsp_wait == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd(cap_addr);
        end
      end
      mem_req_ready = ($urandom % 4) != 0;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        cap_addr = mem_req_addr;
        if (nrd < 4) rd_addr[nrd] = mem_req_addr;
        nrd++;
        rsp_wait = 1 + int'($urandom % 3);
      end
    end
  end

  task automatic run_case(input logic [63:0] va, input logic [1:0] kind, input logic usr, input string tag);
    model(va, kind, usr, root_frame);
    nrd = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_user = usr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    repeat ($urandom % 3) begin
      @(negedge clk);
      chk(res_valid && !req_ready, "R12", "result held", {62'd0, res_valid, req_ready}, 64'd2);
    end
    chk(res_fault_code == exp_code, tag, "fault code", 64'(res_fault_code), 64'(exp_code));
    chk(res_fault == (exp_code != 3'd0), tag, "fault flag", 64'(res_fault), 64'(exp_code != 3'd0));
    chk(res_level == exp_lvl, tag, "level", 64'(res_level), 64'(exp_lvl));
    if (exp_code == 3'd0) begin
      chk(res_paddr == exp_pa, tag, "paddr", 64'(res_paddr), 64'(exp_pa));
      chk(res_page_size == exp_ps, tag, "page size", 64'(res_page_size), 64'(exp_ps));
    end
    chk(nrd == exp_nrd, tag, "read count", 64'(nrd), 64'(exp_nrd));
    for (int i = 0; i < exp_nrd && i < nrd; i++)
      chk(rd_addr[i] == exp_addr[i], tag, "read address", 64'(rd_addr[i]), 64'(exp_addr[i]));
    @(negedge clk);
    res_ack = 1'b1;
    @(negedge clk);
    res_ack = 1'b0;
  endtask

  task automatic build_chain();
    for (int i = 0; i < NTBL * 512; i++) pm[i] = '0;
    put(1, 3, mkent(36'd2, 12'h007, 1'b0));
    put(2, 5, mkent(36'd3, 12'h007, 1'b0));
    put(3, 7, mkent(36'd4, 12'h007, 1'b0));
    put(4, 9, mkent(36'h12345, 12'h007, 1'b0));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] va;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(req_ready && !res_valid && !mem_req_valid, "R12", "reset state",
        {61'd0, req_ready, res_valid, mem_req_valid}, 64'd4);
    rst_n = 1'b1;

    build_chain();
    root_frame = 36'd1;
    va = mkva(3, 5, 7, 9, 12'hABC);
    run_case(va, 2'd0, 1'b1, "R1");
    chk(res_paddr == 48'h12345ABC && exp_nrd == 4, "R2", "4K paddr", 64'(res_paddr), 64'h12345ABC);

    run_case(64'h0001_0000_0000_0000, 2'd0, 1'b0, "R10");
    chk(exp_code == 3'd4 && nrd == 0, "R10", "no read", 64'(nrd), 64'd0);
    run_case(64'hFFFF_0000_0000_1000, 2'd0, 1'b0, "R10");

    put(4, 9, mkent(36'h12345, 12'h087, 1'b0));
    run_case(va, 2'd0, 1'b0, "R4");
    chk(exp_ps == 2'd0 && exp_code == 3'd0, "R4", "level-1 bit 7 no effect", 64'(exp_ps), 64'd0);
    put(3, 7, mkent(36'hABCDE_0000 >> 4, 12'h087, 1'b0));
    run_case(va, 2'd0, 1'b0, "R4");
    chk(exp_ps == 2'd1 && exp_lvl == 3'd2, "R4", "2M end", 64'(exp_ps), 64'd1);
    put(2, 5, mkent(36'hFEDCB_A987 >> 4, 12'h087, 1'b0));
    run_case(va, 2'd1, 1'b1, "R4");
    chk(exp_ps == 2'd2 && exp_lvl == 3'd3, "R4", "1G end", 64'(exp_ps), 64'd2);

    put(1, 3, mkent(36'd2, 12'h087, 1'b0));
    run_case(va, 2'd0, 1'b0, "R5");
    chk(exp_code == 3'd2 && exp_lvl == 3'd4, "R5", "reserved at top", 64'(exp_code), 64'd2);

    build_chain();
    put(2, 5, mkent(36'd3, 12'h005, 1'b0));
    run_case(va, 2'd1, 1'b0, "R6");
    chk(exp_code == 3'd3 && exp_lvl == 3'd3, "R6", "write denied", 64'(exp_code), 64'd3);
    run_case(va, 2'd0, 1'b1, "R6");

    build_chain();
    put(3, 7, mkent(36'd4, 12'h003, 1'b0));
    run_case(va, 2'd0, 1'b1, "R7");
    chk(exp_code == 3'd3 && exp_lvl == 3'd2, "R7", "user denied", 64'(exp_code), 64'd3);
    run_case(va, 2'd1, 1'b0, "R7");

    build_chain();
    put(4, 9, mkent(36'h12345, 12'h007, 1'b1));
    run_case(va, 2'd2, 1'b0, "R8");
    chk(exp_code == 3'd3 && exp_lvl == 3'd1, "R8", "fetch denied", 64'(exp_code), 64'd3);
    run_case(va, 2'd0, 1'b0, "R8");

    put(4, 9, mkent(36'h12345, 12'h006, 1'b0));
    run_case(va, 2'd0, 1'b0, "R3");
    chk(exp_code == 3'd1 && exp_lvl == 3'd1, "R3", "not present low", 64'(exp_code), 64'd1);
    put(1, 3, 64'd0);
    run_case(va, 2'd0, 1'b0, "R3");

    build_chain();
    put(1, 3, mkent(36'd1, 12'h007, 1'b0));
    run_case(mkva(3, 3, 3, 3, 12'h456), 2'd0, 1'b0, "R9");
    chk(exp_code == 3'd0 && exp_pa == 48'h1456, "R9", "self reference", 64'(res_paddr), 64'h1456);

    for (int i = 0; i < NTBL * 512; i++) begin
      logic [63:0] r = {$urandom, $urandom};
      logic [35:0] frm = (($urandom % 4) != 0) ? 36'(1 + ($urandom % NTBL)) : r[35:0];
      logic [11:0] fl = {4'd0, ($urandom % 6) == 0, 4'd0, ($urandom % 8) != 0, ($urandom % 8) != 0, ($urandom % 8) != 0};
      pm[i] = mkent(frm, fl, ($urandom % 8) == 0);
    end
    for (int n = 0; n < 400; n++) begin
      logic [63:0] r = {$urandom, $urandom};
      root_frame = 36'(1 + ($urandom % NTBL));
      va = {{16{r[47]}}, r[47:0]};
      if (($urandom % 16) == 0) va[50] = ~va[50];
      run_case(va, 2'($urandom % 3), 1'($urandom), "R11");
    end
    finish_run();
  end
endmodule